// File: doc/BRIEF.md
# Cost-weighted physical register tracker

This block keeps a running count of occupied physical registers in several rename register files. Each architectural register ID belongs to one file and carries an allocation cost. A wide register may cost two entries where a narrow one costs one. File 0 is a global file that every allocation and every release is also charged to, whichever file owns the register. A static range table, set by parameters, gives each ID its owning file and cost. IDs outside every range belong to file 0 with cost 1.

Each cycle the block accepts three groups of up to `MAX_DST` lanes. The allocate group holds the destination IDs of a dispatched instruction. The release group holds the IDs freed at retirement. The query group holds the destination IDs of a candidate instruction. The query answer is combinational and uses the counts held in the current cycle. Its result is a per-file stall mask, and an all-zero mask means the candidate may dispatch. Allocations and releases in the same cycle are netted into the counters at the clock edge.

A small health state machine holds two sticky faults. States: `HS_CLEAN`, `HS_CFG_BAD`, `HS_UFLOW`, `HS_BOTH`. Transitions: `HS_CLEAN`→`HS_CFG_BAD` on a query larger than a file's total capacity; `HS_CLEAN`→`HS_UFLOW` on a release that would drive a count below zero; `HS_CLEAN`→`HS_BOTH` when both happen in one cycle; `HS_CFG_BAD`→`HS_BOTH` on underflow; `HS_UFLOW`→`HS_BOTH` on an oversize query. Only reset leaves a fault state.

Top module: `phys_reg_budget`

## Requirements
- R1: Reset clears every used count to zero and returns the health machine to `HS_CLEAN`, so that `cfg_err` and `uflow_err` are low.
- R2: Bit f of `qry_stall` (file f at bit position f) is 1 when file f's capacity is less than its used count plus the summed cost of the valid query lanes it owns. File 0 sums the cost of every valid lane. Equality does not stall.
- R3: A file configured with capacity 0 is unbounded, and its stall bit is never set.
- R4: A file that receives no cost from the current query has its stall bit clear, even when it is full. With no valid query lane, `qry_stall` is all zero.
- R5: An allocation adds each valid lane's cost to its owning file (when nonzero) and to file 0, and the new count is seen by queries from the next cycle.
- R6: A release subtracts each valid lane's cost from its owning file and from file 0, and the new count is seen from the next cycle.
- R7: Allocation and release in the same cycle both apply, netted into the counts.
- R8: A query whose per-file cost exceeds that file's nonzero total capacity sets the stall bit and raises `cfg_err` from the next cycle, and `cfg_err` stays high until reset.
- R9: A release that would take any count below zero raises `uflow_err` from the next cycle and leaves that count at zero. `uflow_err` stays high until reset.
- R10: Lanes whose valid bit is low have no effect on counts or on the stall mask.
- R11: Queries never change the counts.
- R12: Map used by the bench and by the defaults: IDs 16–31 belong to file 1 with cost 1; IDs 32–47 belong to file 1 with cost 2; IDs 48–55 belong to file 2 with cost 1; IDs 56–63 belong to file 3 with cost 1; IDs 0–15 belong to file 0 with cost 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_vld | input | MAX_DST | Valid bit per allocate lane |
| alloc_id | input | MAX_DST×clog2(NUM_ARCH) | Register ID per allocate lane, lane 0 in the low bits |
| free_vld | input | MAX_DST | Valid bit per release lane |
| free_id | input | MAX_DST×clog2(NUM_ARCH) | Register ID per release lane |
| qry_vld | input | MAX_DST | Valid bit per query lane |
| qry_id | input | MAX_DST×clog2(NUM_ARCH) | Register ID per query lane |
| qry_stall | output | NUM_FILES | Per-file shortage mask for the current query |
| cfg_err | output | 1 | Sticky oversize-query fault |
| uflow_err | output | 1 | Sticky count underflow fault |

## Verification
The bench builds the block with four files of capacity 12, 6, 3 and 0, four lanes and the default 64-ID map. These small capacities let a handful of instructions reach every boundary: the exact-fit case, a single-entry overrun, a full file that is not queried, and the unbounded file. A cost-2 range in file 1 shows that wide registers are charged twice. Because file 0 tracks everything with a capacity of only 12, the global shortage can be triggered even while every owning file still has room.

// File: rtl/prt_pkg.sv
package prt_pkg;

    typedef enum logic [1:0] {
        HS_CLEAN   = 2'd0,
        HS_CFG_BAD = 2'd1,
        HS_UFLOW   = 2'd2,
        HS_BOTH    = 2'd3
    } health_e;

endpackage

// File: rtl/prt_cost_map.sv
// Static lookup: register ID -> (owning file, allocation cost).
// The lowest-numbered matching range wins; no match gives file 0, cost 1.
module prt_cost_map #(
    parameter int ID_W       = 6,
    parameter int FILE_W     = 2,
    parameter int COST_W     = 2,
    parameter int NUM_RANGES = 4,
    parameter int RANGE_LO   [NUM_RANGES] = '{16, 32, 48, 56},
    parameter int RANGE_HI   [NUM_RANGES] = '{31, 47, 55, 63},
    parameter int RANGE_FILE [NUM_RANGES] = '{1, 1, 2, 3},
    parameter int RANGE_COST [NUM_RANGES] = '{1, 2, 1, 1}
) (
    input  logic [ID_W-1:0]   id_i,
    output logic [FILE_W-1:0] file_o,
    output logic [COST_W-1:0] cost_o
);

    always_comb begin
        file_o = '0;
        cost_o = COST_W'(1);
        for (int r = NUM_RANGES - 1; r >= 0; r--) begin
            if (int'(id_i) >= RANGE_LO[r] && int'(id_i) <= RANGE_HI[r]) begin
                file_o = FILE_W'(RANGE_FILE[r]);
                cost_o = COST_W'(RANGE_COST[r]);
            end
        end
    end

endmodule

// File: rtl/prt_file_sum.sv
// Adds the cost of every valid lane into its owning file and into file 0.
module prt_file_sum #(
    parameter int NUM_FILES = 4,
    parameter int LANES     = 4,
    parameter int FILE_W    = 2,
    parameter int COST_W    = 2,
    parameter int REQ_W     = 5
) (
    input  logic [LANES-1:0]                 vld_i,
    input  logic [LANES-1:0][FILE_W-1:0]     file_i,
    input  logic [LANES-1:0][COST_W-1:0]     cost_i,
    output logic [NUM_FILES-1:0][REQ_W-1:0]  sum_o
);

    always_comb begin
        sum_o = '0;
        for (int l = 0; l < LANES; l++) begin
            if (vld_i[l]) begin
                sum_o[0] = sum_o[0] + REQ_W'(cost_i[l]);
                if (file_i[l] != '0 && int'(file_i[l]) < NUM_FILES) begin
                    sum_o[file_i[l]] = sum_o[file_i[l]] + REQ_W'(cost_i[l]);
                end
            end
        end
    end

endmodule

// File: rtl/prt_health_fsm.sv
// Sticky fault tracking: oversize query and count underflow.
module prt_health_fsm
    import prt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_hit_i,
    input  logic uflow_hit_i,
    output logic cfg_err_o,
    output logic uflow_err_o
);

    health_e state_q;
    health_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_CLEAN: begin
                if (cfg_hit_i && uflow_hit_i) begin
                    state_d = HS_BOTH;
                end else if (cfg_hit_i) begin
                    state_d = HS_CFG_BAD;
                end else if (uflow_hit_i) begin
                    state_d = HS_UFLOW;
                end
            end
            HS_CFG_BAD: begin
                if (uflow_hit_i) begin
                    state_d = HS_BOTH;
                end
            end
            HS_UFLOW: begin
                if (cfg_hit_i) begin
                    state_d = HS_BOTH;
                end
            end
            HS_BOTH: begin
                state_d = HS_BOTH;
            end
            default: begin
                state_d = HS_CLEAN;
            end
        endcase
    end

    always_comb begin
        cfg_err_o   = 1'b0;
        uflow_err_o = 1'b0;
        unique case (state_q)
            HS_CLEAN:   begin end
            HS_CFG_BAD: cfg_err_o = 1'b1;
            HS_UFLOW:   uflow_err_o = 1'b1;
            HS_BOTH: begin
                cfg_err_o   = 1'b1;
                uflow_err_o = 1'b1;
            end
            default:    begin end
        endcase
    end

endmodule

// File: rtl/phys_reg_budget.sv
module phys_reg_budget #(
    parameter int NUM_FILES  = 4,
    parameter int NUM_ARCH   = 64,
    parameter int CNT_W      = 8,
    parameter int MAX_DST    = 4,
    parameter int COST_W     = 2,
    parameter int NUM_RANGES = 4,
    parameter int FILE_CAP   [NUM_FILES]  = '{96, 72, 32, 0},
    parameter int RANGE_LO   [NUM_RANGES] = '{16, 32, 48, 56},
    parameter int RANGE_HI   [NUM_RANGES] = '{31, 47, 55, 63},
    parameter int RANGE_FILE [NUM_RANGES] = '{1, 1, 2, 3},
    parameter int RANGE_COST [NUM_RANGES] = '{1, 2, 1, 1}
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [MAX_DST-1:0]                          alloc_vld,
    input  logic [MAX_DST-1:0][$clog2(NUM_ARCH)-1:0]    alloc_id,
    input  logic [MAX_DST-1:0]                          free_vld,
    input  logic [MAX_DST-1:0][$clog2(NUM_ARCH)-1:0]    free_id,
    input  logic [MAX_DST-1:0]                          qry_vld,
    input  logic [MAX_DST-1:0][$clog2(NUM_ARCH)-1:0]    qry_id,
    output logic [NUM_FILES-1:0]                        qry_stall,
    output logic                                        cfg_err,
    output logic                                        uflow_err
);

    localparam int ID_W   = $clog2(NUM_ARCH);
    localparam int FILE_W = (NUM_FILES > 1) ? $clog2(NUM_FILES) : 1;
    localparam int REQ_W  = COST_W + $clog2(MAX_DST + 1);
    localparam int WIDE_W = CNT_W + REQ_W + 1;
    localparam logic [WIDE_W-1:0] CNT_MAX = WIDE_W'((64'd1 << CNT_W) - 64'd1);

    // Per-lane lookups for the three groups.
    logic [MAX_DST-1:0][FILE_W-1:0] a_file, f_file, q_file;
    logic [MAX_DST-1:0][COST_W-1:0] a_cost, f_cost, q_cost;

    for (genvar g = 0; g < MAX_DST; g++) begin : g_lane
        prt_cost_map #(
            .ID_W(ID_W), .FILE_W(FILE_W), .COST_W(COST_W), .NUM_RANGES(NUM_RANGES),
            .RANGE_LO(RANGE_LO), .RANGE_HI(RANGE_HI),
            .RANGE_FILE(RANGE_FILE), .RANGE_COST(RANGE_COST)
        ) u_map_alloc (
            .id_i(alloc_id[g]), .file_o(a_file[g]), .cost_o(a_cost[g])
        );
        prt_cost_map #(
            .ID_W(ID_W), .FILE_W(FILE_W), .COST_W(COST_W), .NUM_RANGES(NUM_RANGES),
            .RANGE_LO(RANGE_LO), .RANGE_HI(RANGE_HI),
            .RANGE_FILE(RANGE_FILE), .RANGE_COST(RANGE_COST)
        ) u_map_free (
            .id_i(free_id[g]), .file_o(f_file[g]), .cost_o(f_cost[g])
        );
        prt_cost_map #(
            .ID_W(ID_W), .FILE_W(FILE_W), .COST_W(COST_W), .NUM_RANGES(NUM_RANGES),
            .RANGE_LO(RANGE_LO), .RANGE_HI(RANGE_HI),
            .RANGE_FILE(RANGE_FILE), .RANGE_COST(RANGE_COST)
        ) u_map_qry (
            .id_i(qry_id[g]), .file_o(q_file[g]), .cost_o(q_cost[g])
        );
    end

    // Per-file cost totals for each group.
    logic [NUM_FILES-1:0][REQ_W-1:0] a_sum, f_sum, q_sum;

    prt_file_sum #(
        .NUM_FILES(NUM_FILES), .LANES(MAX_DST), .FILE_W(FILE_W),
        .COST_W(COST_W), .REQ_W(REQ_W)
    ) u_sum_alloc (
        .vld_i(alloc_vld), .file_i(a_file), .cost_i(a_cost), .sum_o(a_sum)
    );

    prt_file_sum #(
        .NUM_FILES(NUM_FILES), .LANES(MAX_DST), .FILE_W(FILE_W),
        .COST_W(COST_W), .REQ_W(REQ_W)
    ) u_sum_free (
        .vld_i(free_vld), .file_i(f_file), .cost_i(f_cost), .sum_o(f_sum)
    );

    prt_file_sum #(
        .NUM_FILES(NUM_FILES), .LANES(MAX_DST), .FILE_W(FILE_W),
        .COST_W(COST_W), .REQ_W(REQ_W)
    ) u_sum_qry (
        .vld_i(qry_vld), .file_i(q_file), .cost_i(q_cost), .sum_o(q_sum)
    );

    // Used counters, netting allocation against release.
    logic [CNT_W-1:0]     used_q [NUM_FILES];
    logic [CNT_W-1:0]     used_d [NUM_FILES];
    logic [NUM_FILES-1:0] uflow_vec;
    logic [NUM_FILES-1:0] cfg_vec;

    for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
        localparam logic [WIDE_W-1:0] CAP = WIDE_W'(FILE_CAP[f]);
        localparam bit BOUNDED = (FILE_CAP[f] != 0);

        logic [WIDE_W-1:0] base, grown, rel, diff, need, ask;
        logic              asked;

        assign base  = WIDE_W'(used_q[f]);
        assign grown = base + WIDE_W'(a_sum[f]);
        assign rel   = WIDE_W'(f_sum[f]);
        assign diff  = grown - rel;
        assign ask   = WIDE_W'(q_sum[f]);
        assign need  = base + ask;
        assign asked = (q_sum[f] != '0);

        assign uflow_vec[f] = (grown < rel);
        assign used_d[f]    = (grown < rel)   ? '0 :
                              (diff > CNT_MAX) ? '1 : diff[CNT_W-1:0];

        assign qry_stall[f] = BOUNDED && asked && (CAP < need);
        assign cfg_vec[f]   = BOUNDED && asked && (CAP < ask);
    end

    always_ff @(posedge clk) begin
        for (int f = 0; f < NUM_FILES; f++) begin
            if (!rst_n) begin
                used_q[f] <= '0;
            end else begin
                used_q[f] <= used_d[f];
            end
        end
    end

    prt_health_fsm u_health (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_hit_i   (|cfg_vec),
        .uflow_hit_i (|uflow_vec),
        .cfg_err_o   (cfg_err),
        .uflow_err_o (uflow_err)
    );

endmodule

// File: rtl/phys_reg_budget_chk.sv
module phys_reg_budget_chk #(
    parameter int NUM_FILES = 4,
    parameter int MAX_DST   = 4,
    parameter int FILE_CAP [NUM_FILES] = '{96, 72, 32, 0}
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [MAX_DST-1:0]   qry_vld,
    input logic [MAX_DST-1:0]   free_vld,
    input logic [NUM_FILES-1:0] qry_stall,
    input logic                 cfg_err,
    input logic                 uflow_err
);

    for (genvar f = 0; f < NUM_FILES; f++) begin : g_unb
        if (FILE_CAP[f] == 0) begin : g_zero
            // R3
            unbounded_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !qry_stall[f]);
        end
    end

    // R4
    idle_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_vld == '0) |-> (qry_stall == '0));

    // R8
    cfg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R8
    cfg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $past(qry_vld != '0));

    // R9
    uflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uflow_err |=> uflow_err);

    // R9
    uflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uflow_err) |-> $past(free_vld != '0));

endmodule

bind phys_reg_budget phys_reg_budget_chk #(
    .NUM_FILES (NUM_FILES),
    .MAX_DST   (MAX_DST),
    .FILE_CAP  (FILE_CAP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .qry_vld   (qry_vld),
    .free_vld  (free_vld),
    .qry_stall (qry_stall),
    .cfg_err   (cfg_err),
    .uflow_err (uflow_err)
);

// File: tb/test_phys_reg_budget.sv
module test_phys_reg_budget;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  a_vld = '0, f_vld = '0, q_vld = '0;
    logic [23:0] a_id = '0, f_id = '0, q_id = '0;
    logic [3:0]  stall;
    logic        cfg_err, uflow_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    phys_reg_budget #(
        .NUM_FILES(4), .NUM_ARCH(64), .CNT_W(8), .MAX_DST(4), .COST_W(2),
        .NUM_RANGES(4),
        .FILE_CAP('{12, 6, 3, 0})
    ) i_phys_reg_budget (
        .clk(clk), .rst_n(rst_n),
        .alloc_vld(a_vld), .alloc_id(a_id),
        .free_vld(f_vld), .free_id(f_id),
        .qry_vld(q_vld), .qry_id(q_id),
        .qry_stall(stall), .cfg_err(cfg_err), .uflow_err(uflow_err)
    );

    // Map (R12): 0-15 f0 c1, 16-31 f1 c1, 32-47 f1 c2, 48-55 f2 c1, 56-63 f3 c1.
    // Caps: f0=12, f1=6, f2=3, f3=0 (unbounded). Lane 0 is the rightmost id.
    typedef struct packed {
        logic [3:0]  av;
        logic [23:0] ai;
        logic [3:0]  fv;
        logic [23:0] fi;
        logic [3:0]  qv;
        logic [23:0] qi;
        logic [3:0]  st;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // 0: f1 asks 6 of 6, exact fit
        '{4'b0000, 24'd0, 4'b0000, 24'd0, 4'b0111, {6'd0, 6'd34, 6'd33, 6'd32}, 4'b0000},
        // 1: alloc 32,33 (f1 +4)
        '{4'b0011, {6'd0, 6'd0, 6'd33, 6'd32}, 4'b0000, 24'd0, 4'b0001, {6'd0, 6'd0, 6'd0, 6'd34}, 4'b0000},
        // 2: f1 4+3 > 6
        '{4'b0000, 24'd0, 4'b0000, 24'd0, 4'b0011, {6'd0, 6'd0, 6'd16, 6'd34}, 4'b0010},
        // 3: f1 4+2 fits; alloc 48..50 (f2 +3)
        '{4'b0111, {6'd0, 6'd50, 6'd49, 6'd48}, 4'b0000, 24'd0, 4'b0001, {6'd0, 6'd0, 6'd0, 6'd34}, 4'b0000},
        // 4: f2 3+1 > 3; alloc 56..59 (f3)
        '{4'b1111, {6'd59, 6'd58, 6'd57, 6'd56}, 4'b0000, 24'd0, 4'b0011, {6'd0, 6'd0, 6'd0, 6'd51}, 4'b0100},
        // 5: f3 unbounded, f0 11+4 > 12
        '{4'b0000, 24'd0, 4'b0000, 24'd0, 4'b1111, {6'd63, 6'd62, 6'd61, 6'd60}, 4'b0001},
        // 6: f0 11+1 fits; free 56,57
        '{4'b0000, 24'd0, 4'b0011, {6'd0, 6'd0, 6'd57, 6'd56}, 4'b0001, {6'd0, 6'd0, 6'd0, 6'd1}, 4'b0000},
        // 7: f0 9+3 fits; alloc 0 and free 32 together
        '{4'b0001, {6'd0, 6'd0, 6'd0, 6'd0}, 4'b0001, {6'd0, 6'd0, 6'd0, 6'd32}, 4'b0111, {6'd0, 6'd62, 6'd61, 6'd60}, 4'b0000},
        // 8: f1 2+4 fits, f0 8+6 > 12
        '{4'b0000, 24'd0, 4'b0000, 24'd0, 4'b1111, {6'd1, 6'd0, 6'd33, 6'd32}, 4'b0001},
        // 9: full f2 not asked; invalid lanes carry ids
        '{4'b0000, {6'd0, 6'd0, 6'd35, 6'd34}, 4'b0000, {6'd0, 6'd0, 6'd33, 6'd32}, 4'b0001, {6'd48, 6'd48, 6'd48, 6'd16}, 4'b0000},
        // 10: f1 still 2: 2+4 fits
        '{4'b0000, 24'd0, 4'b0000, 24'd0, 4'b0011, {6'd0, 6'd0, 6'd33, 6'd32}, 4'b0000}
    };

    string vtag [NV] = '{"R2", "R5", "R2", "R5", "R3", "R3", "R6", "R7", "R2", "R4", "R10"};

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] av, input logic [23:0] ai,
                        input logic [3:0] fv, input logic [23:0] fi,
                        input logic [3:0] qv, input logic [23:0] qi);
        @(negedge clk);
        a_vld = av; a_id = ai;
        f_vld = fv; f_id = fi;
        q_vld = qv; q_id = qi;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 cfg_err after reset", {3'b0, cfg_err}, 4'b0000);
        chk("R1 uflow_err after reset", {3'b0, uflow_err}, 4'b0000);

        for (int v = 0; v < NV; v++) begin
            step(VECS[v].av, VECS[v].ai, VECS[v].fv, VECS[v].fi, VECS[v].qv, VECS[v].qi);
            chk(vtag[v], stall, VECS[v].st);
        end
        // counts now: f0=8, f1=2, f2=3

        // R10: invalid release lanes in vector 9 caused no underflow
        step(4'b0, 24'd0, 4'b0, 24'd0, 4'b0, 24'd0);
        chk("R10 no underflow from invalid lanes", {3'b0, uflow_err}, 4'b0000);

        // R11: repeated queries leave counts alone (f1 2+4, f0 8+4)
        for (int k = 0; k < 3; k++) begin
            step(4'b0, 24'd0, 4'b0, 24'd0, 4'b0011, {6'd0, 6'd0, 6'd35, 6'd34});
            chk("R11 repeated query", stall, 4'b0000);
        end

        // R8: f1 asks 8 > capacity 6
        step(4'b0, 24'd0, 4'b0, 24'd0, 4'b1111, {6'd35, 6'd34, 6'd33, 6'd32});
        chk("R8 oversize stall", stall, 4'b0011);
        chk("R8 cfg_err not yet", {3'b0, cfg_err}, 4'b0000);
        step(4'b0, 24'd0, 4'b0, 24'd0, 4'b0, 24'd0);
        chk("R8 cfg_err raised", {3'b0, cfg_err}, 4'b0001);
        step(4'b0, 24'd0, 4'b0, 24'd0, 4'b0, 24'd0);
        chk("R8 cfg_err sticky", {3'b0, cfg_err}, 4'b0001);
        chk("R9 uflow_err still low", {3'b0, uflow_err}, 4'b0000);

        // R9: release 4 from f2 holding 3
        step(4'b0, 24'd0, 4'b1111, {6'd51, 6'd50, 6'd49, 6'd48}, 4'b0, 24'd0);
        step(4'b0, 24'd0, 4'b0, 24'd0, 4'b0111, {6'd0, 6'd50, 6'd49, 6'd48});
        chk("R9 uflow_err raised", {3'b0, uflow_err}, 4'b0001);
        chk("R9 count clamped to zero", stall, 4'b0000);
        step(4'b0, 24'd0, 4'b0, 24'd0, 4'b0, 24'd0);
        chk("R9 uflow_err sticky", {3'b0, uflow_err}, 4'b0001);

        // R1: reset again clears faults and counts (f1 was 2)
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        q_vld = 4'b0111; q_id = {6'd0, 6'd34, 6'd33, 6'd32};
        #1;
        chk("R1 counts cleared", stall, 4'b0000);
        chk("R1 cfg_err cleared", {3'b0, cfg_err}, 4'b0000);
        chk("R1 uflow_err cleared", {3'b0, uflow_err}, 4'b0000);
        step(4'b0, 24'd0, 4'b0, 24'd0, 4'b0, 24'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule